// File: doc/BRIEF.md
# Cycle-Wrap Interrupt Timer

This block is a free-running up-counter that the CPU arms through two byte-wide write ports. The counter is `CNT_W` bits wide (16 by default). It is split into byte lanes, and each lane has its own address starting at `BASE_ADDR` (0x4100 for the low byte, 0x4101 for the high byte). Once the count holds a nonzero value, it advances by one on every CPU bus cycle. When it passes from all ones to zero, an active-high interrupt request is latched.

A count of zero is a parked state. The counter stops there after a wrap and remains there until software loads a new value. The low-byte write port also serves as the acknowledge: a write to it both loads the byte and drops the request. A write to the high byte only loads that byte. A register write always takes precedence over the increment in the same cycle.

Top module: `cyc_irq_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the count is zero and `irq` is 0.
- R2: A cycle with `wr_en`=1 and `addr`=0x4100 loads `wdata` into count bits [7:0]. A cycle with `wr_en`=1 and `addr`=0x4101 loads `wdata` into count bits [15:8]. The other byte is kept.
- R3: In a cycle with no register write, a nonzero count increases by exactly one.
- R4: A count of zero does not change unless it is written, so `irq` never rises from a zero count.
- R5: In a cycle with no register write, a count of 0xFFFF becomes 0x0000 and `irq` goes to 1 at that same clock edge.
- R6: Once set, `irq` stays 1 until a write to 0x4100. A write to 0x4100 clears it at the next edge. A write to 0x4101 leaves it set.
- R7: In a cycle with a register write, the written byte replaces that lane and no increment happens.
- R8: Writes with `wr_en`=0, and writes to any address other than 0x4100 or 0x4101, change neither the count nor `irq`.
- R9: A write to 0x4100 in the cycle where the count is 0xFFFF suppresses the wrap, so `irq` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter, 8-bit lanes and a base address of 0x4100. With these values, any load close to 0xFFFF reaches the wrap within a few cycles, which makes the write-versus-wrap collisions and the acknowledge timing checkable cycle by cycle. The full 16-bit width is still small enough for the bench to run loads such as 0x8000 and 0x0001 all the way to the wrap, so the long-count path is also covered.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int DEF_LANE_W = 8;
    localparam int DEF_LANES  = 2;
    localparam int DEF_ADDR_W = 16;
endpackage

// File: rtl/cit_decode.sv
module cit_decode #(
    parameter int ADDR_W = cit_pkg::DEF_ADDR_W,
    parameter int LANES  = cit_pkg::DEF_LANES,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [LANES-1:0]  lane_sel
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_sel[i] = wr_en && (addr == BASE_ADDR + ADDR_W'(i));
    end
endmodule

// File: rtl/cit_count.sv
module cit_count #(
    parameter int LANE_W = cit_pkg::DEF_LANE_W,
    parameter int LANES  = cit_pkg::DEF_LANES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          lane_sel,
    input  logic [LANE_W-1:0]         wdata,
    output logic [LANES*LANE_W-1:0]   cnt_o,
    output logic                      wrap_o
);
    localparam int CNT_W = LANES * LANE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic any_wr;

    always_comb begin
        any_wr = |lane_sel;
        st_d   = st_q;
        wrap_o = 1'b0;
        if (any_wr) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_sel[i]) st_d.cnt[i*LANE_W +: LANE_W] = wdata;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_o   = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/cit_irqflag.sv
module cit_irqflag (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic wrap,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack)       st_d.pend = 1'b0;
        else if (wrap) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend;
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
    parameter int LANE_W = cit_pkg::DEF_LANE_W,
    parameter int LANES  = cit_pkg::DEF_LANES,
    parameter int ADDR_W = cit_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    input  logic              wr_en,
    output logic              irq
);
    localparam int CNT_W = LANES * LANE_W;

    logic [LANES-1:0] lane_sel;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    cit_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(addr), .wr_en(wr_en), .lane_sel(lane_sel)
    );

    cit_count #(.LANE_W(LANE_W), .LANES(LANES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel), .wdata(wdata),
        .cnt_o(cnt_q), .wrap_o(wrap)
    );

    // lane 0 write is the acknowledge
    cit_irqflag u_flag (
        .clk(clk), .rst_n(rst_n), .ack(lane_sel[0]), .wrap(wrap), .irq_o(irq)
    );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4100
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic [LANE_W-1:0]       wdata,
    input logic                    wr_en,
    input logic                    irq,
    input logic [LANES*LANE_W-1:0] cnt
);
    logic wr_lo, wr_any;
    assign wr_lo  = wr_en && (addr == BASE_ADDR);
    assign wr_any = wr_en && (addr >= BASE_ADDR) && (addr < BASE_ADDR + ADDR_W'(LANES));

    // R2
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt[LANE_W-1:0] == $past(wdata));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && cnt != '0 && !(&cnt)) |=> cnt == $past(cnt) + 1'b1);
    // R4
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && cnt == '0) |=> cnt == '0);
    // R5
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && (&cnt)) |=> (irq && cnt == '0));
    // R6
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !irq);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_lo) |=> irq);
    // R8
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && !irq && !(&cnt)) |=> !irq);
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
    .LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .irq(irq), .cnt(cnt_q)
);

// File: tb/cyc_irq_timer_test.sv
`timescale 1ns/1ps
module cyc_irq_timer_test;
    localparam logic [15:0] A_LO = 16'h4100;
    localparam logic [15:0] A_HI = 16'h4101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    logic [15:0] m_cnt = '0;
    bit          m_irq = 1'b0;

    always #4 clk = ~clk;

    cyc_irq_timer uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .irq(irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one bus cycle, model from the requirements, push expected irq
    task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d;
        if (we && a == A_LO) begin
            m_cnt[7:0] = d; m_irq = 1'b0;
        end else if (we && a == A_HI) begin
            m_cnt[15:8] = d;
        end else if (m_cnt != 16'h0) begin
            if (m_cnt == 16'hFFFF) m_irq = 1'b1;
            m_cnt = m_cnt + 16'd1;
        end
        exp_q.push_back(m_irq);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 8'h0, tag);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) check(tag_q.pop_front(), irq, exp_q.pop_front());
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: irq=%0b expected run end", irq);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", irq, 1'b0);
        rst_n = 1'b1;
        idle(20, "R1 R4 zero parked");
        // R2 R3 R5: load 0xFFF0 and let it wrap
        step(1'b1, A_HI, 8'hFF, "R2 hi load");
        step(1'b1, A_LO, 8'hF0, "R2 lo load");
        idle(25, "R3 R5 wrap");
        // R6 high write is no ack
        step(1'b1, A_HI, 8'h00, "R6 hi no ack");
        idle(4, "R6 hold");
        // R8 ignored writes
        step(1'b1, 16'h4102, 8'hFF, "R8 other addr");
        step(1'b1, 16'h4000, 8'hFF, "R8 other addr");
        @(negedge clk);
        idle(1, "R8 pre");
        step(1'b0, A_LO, 8'h55, "R8 strobe low");
        idle(3, "R8 still pending");
        step(1'b1, A_LO, 8'h00, "R6 ack");
        idle(300, "R4 R8 parked after ack");
        // R7 repeated writes hold the count
        step(1'b1, A_HI, 8'hFF, "R7 setup");
        for (int i = 0; i < 5; i++) step(1'b1, A_LO, 8'hFE, "R7 write wins");
        idle(6, "R7 R5 wrap after writes");
        step(1'b1, A_LO, 8'h00, "R6 ack");
        // R9 ack collides with wrap
        step(1'b1, A_HI, 8'hFF, "R9 setup");
        step(1'b1, A_LO, 8'hFF, "R9 setup");
        step(1'b1, A_LO, 8'h00, "R9 write over wrap");
        idle(270, "R9 R3 later wrap");
        step(1'b1, A_LO, 8'h00, "R6 ack");
        step(1'b1, A_HI, 8'h00, "R6 ack");
        // long runs
        step(1'b1, A_HI, 8'h80, "R3 long");
        idle(32800, "R3 R5 long 0x8000");
        step(1'b1, A_LO, 8'h01, "R6 ack load");
        idle(65600, "R3 R5 long 0x00xx");
        @(posedge clk); #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule